// File: doc/BRIEF.md
# Square-Array Static Memory with Chip Controls

This block is a small random-access memory. Its cells are stored as a square grid: one register per row, one bit per column. Outside the block it looks like a tall, narrow device of many short words. The upper address bits go to a row decoder, which raises a single word line. The lower address bits pick one column group of that row. On a read, a multiplexer selects the group. On a write, a demultiplexer builds a bit mask for the group.

Three active-low controls manage the device:
- **Chip select** (`cs_n`) qualifies everything else.
- **Write strobe** (`we_n`) is active low, and a write takes effect when it is released.
- **Output enable** (`oe_n`) requests that read data be driven.

The data pin is split into an input bus, an output bus and a drive flag. A surrounding pad or bus model can combine them.

All inputs are sampled on `clk`, and the outputs are registered. A write commits on the first sample that sees the strobe high after a low sample, with the chip selected in both samples. The address and data used are the ones present at that release sample. The side of the array is 2^`SIDE_BITS`. The external word width is 2^`WORD_BITS`, where `WORD_BITS` must be less than `SIDE_BITS`. The defaults give 4x4 cells seen as 16x1. `WORD_BITS=1` gives 8x2 from the same array.

Top module: `sqmem_top`

## Requirements
- R1: Every address holds its own word. The upper `SIDE_BITS` address bits choose the row and the lower bits choose the column group. A word written at an address is read back unchanged.
- R2: A write commits only on the sample where `we_n` is first seen high after a low sample, with `cs_n` low in both samples. It stores the `din` and `addr` present at that release sample, not the values present when the strobe fell.
- R3: While `cs_n` is high, the device ignores its other inputs:
  - one clock later, `dout_en` is 0 and `dout` is 0;
  - a strobe that falls or rises while `cs_n` is high writes nothing.
- R4: One clock after a sample with `cs_n`=0, `oe_n`=0 and `we_n`=1:
  - `dout_en` is 1;
  - `dout` holds the addressed word.
  - If `oe_n` is 1 instead, `dout_en` is 0 and `dout` is 0.
- R5: While `we_n` is low with the chip selected, the write wins over a read. One clock later, `dout_en` is 0 even when `oe_n` is 0.
- R6: In the first cycle after synchronous reset, `dout_en` is 0 and `dout` is 0.
- R7: With `WORD_BITS`=1, the same array serves 8 words of 2 bits. Each 2-bit word reads back as written.
- R8: A write changes only the addressed word. Other cells in the same row and in the same column keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; commits on release |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 2*SIDE_BITS-WORD_BITS | Word address: row bits above column bits |
| din | input | 2^WORD_BITS | Write data |
| dout | output | 2^WORD_BITS | Read data, zero while not driven |
| dout_en | output | 1 | High while the device drives read data |

## Verification
On every cycle, the assertions check three rules about the output flag:
- it stays low after a deselected sample;
- the write strobe forces it low;
- a plain read raises it.

They also check that the decoder raises exactly one word line, that the column mask covers exactly one word, and that every commit follows a selected low strobe sample.

Only the bench scenarios can show whether data actually lands in the right cell and reads back. The same holds for:
- neighbours that stay intact after a write;
- data sampled at the release edge rather than the falling edge;
- strobes cut short by deselection, which leave memory unchanged;
- the 8x2 configuration, which uses a separate instance.

// File: rtl/sqmem_pkg.sv
package sqmem_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WHOLD = 2'd2
  } acc_t;

  function automatic acc_t classify(input logic cs_n, input logic we_n, input logic oe_n);
    if (cs_n)       return ACC_IDLE;
    else if (!we_n) return ACC_WHOLD;
    else if (!oe_n) return ACC_READ;
    else            return ACC_IDLE;
  endfunction

endpackage

// File: rtl/sqmem_row_dec.sv
module sqmem_row_dec #(
  parameter int SIDE_BITS = 2,
  localparam int SIDE = 1 << SIDE_BITS
) (
  input  logic [SIDE_BITS-1:0] row,
  output logic [SIDE-1:0]      wordline
);
  for (genvar r = 0; r < SIDE; r++) begin : g_wl
    assign wordline[r] = (row == SIDE_BITS'(r));
  end
endmodule

// File: rtl/sqmem_col_demux.sv
module sqmem_col_demux #(
  parameter int SIDE_BITS = 2,
  parameter int WORD_BITS = 0,
  localparam int SIDE = 1 << SIDE_BITS,
  localparam int W = 1 << WORD_BITS,
  localparam int GROUPS = SIDE / W,
  localparam int COL_BITS = SIDE_BITS - WORD_BITS
) (
  input  logic [COL_BITS-1:0] col,
  output logic [SIDE-1:0]     bit_mask
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign bit_mask[g*W +: W] = {W{col == COL_BITS'(g)}};
  end
endmodule

// File: rtl/sqmem_col_mux.sv
module sqmem_col_mux #(
  parameter int SIDE_BITS = 2,
  parameter int WORD_BITS = 0,
  localparam int SIDE = 1 << SIDE_BITS,
  localparam int W = 1 << WORD_BITS,
  localparam int GROUPS = SIDE / W,
  localparam int COL_BITS = SIDE_BITS - WORD_BITS
) (
  input  logic [SIDE-1:0]     row_bits,
  input  logic [COL_BITS-1:0] col,
  output logic [W-1:0]        word
);
  always_comb begin
    word = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (col == COL_BITS'(g)) word = row_bits[g*W +: W];
    end
  end
endmodule

// File: rtl/sqmem_cell_array.sv
module sqmem_cell_array #(
  parameter int SIDE_BITS = 2,
  localparam int SIDE = 1 << SIDE_BITS
) (
  input  logic                 clk,
  input  logic                 commit,
  input  logic [SIDE-1:0]      wordline,
  input  logic [SIDE-1:0]      bit_mask,
  input  logic [SIDE-1:0]      wr_bits,
  input  logic [SIDE_BITS-1:0] rd_row,
  output logic [SIDE-1:0]      rd_bits
);
  logic [SIDE-1:0] rows [SIDE];

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    logic [SIDE-1:0] cells_q;
    always_ff @(posedge clk) begin
      if (commit && wordline[r])
        cells_q <= (cells_q & ~bit_mask) | (wr_bits & bit_mask);
    end
    assign rows[r] = cells_q;
  end

  assign rd_bits = rows[rd_row];
endmodule

// File: rtl/sqmem_top.sv
module sqmem_top
  import sqmem_pkg::*;
#(
  parameter int SIDE_BITS = 2,
  parameter int WORD_BITS = 0,
  localparam int SIDE = 1 << SIDE_BITS,
  localparam int W = 1 << WORD_BITS,
  localparam int GROUPS = SIDE / W,
  localparam int COL_BITS = SIDE_BITS - WORD_BITS,
  localparam int ADDR_W = SIDE_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout,
  output logic              dout_en
);
  logic [SIDE_BITS-1:0] row;
  logic [COL_BITS-1:0]  col;
  logic [SIDE-1:0]      wordline, bit_mask, rd_bits;
  logic [W-1:0]         rd_word;
  logic                 we_q, commit;
  acc_t                 acc;

  assign row = addr[ADDR_W-1 -: SIDE_BITS];
  assign col = addr[COL_BITS-1:0];
  assign acc = classify(cs_n, we_n, oe_n);

  // strobe history is forced to "released" while deselected
  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= cs_n ? 1'b1 : we_n;
  end
  assign commit = !cs_n && we_n && !we_q;

  sqmem_row_dec #(.SIDE_BITS(SIDE_BITS)) u_dec (
    .row(row), .wordline(wordline));

  sqmem_col_demux #(.SIDE_BITS(SIDE_BITS), .WORD_BITS(WORD_BITS)) u_demux (
    .col(col), .bit_mask(bit_mask));

  sqmem_cell_array #(.SIDE_BITS(SIDE_BITS)) u_cells (
    .clk(clk), .commit(commit), .wordline(wordline), .bit_mask(bit_mask),
    .wr_bits({GROUPS{din}}), .rd_row(row), .rd_bits(rd_bits));

  sqmem_col_mux #(.SIDE_BITS(SIDE_BITS), .WORD_BITS(WORD_BITS)) u_mux (
    .row_bits(rd_bits), .col(col), .word(rd_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (acc == ACC_READ) begin
      dout    <= rd_word;
      dout_en <= 1'b1;
    end else begin
      dout    <= '0;
      dout_en <= 1'b0;
    end
  end

  a_r1_one_wordline: assert property (@(posedge clk) disable iff (rst)
    $onehot(wordline));

  a_r7_mask_one_word: assert property (@(posedge clk) disable iff (rst)
    $countones(bit_mask) == W);

  a_r2_commit_after_low: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(!rst) && $past(!we_n) && $past(!cs_n));

  a_r3_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(cs_n) |-> !dout_en && dout == '0);

  a_r5_write_wins: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(!cs_n && !we_n) |-> !dout_en);

  a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $past(!cs_n && !oe_n && we_n) |-> dout_en);
endmodule

// File: tb/tb_sqmem_top.sv
module tb_sqmem_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic       din = 1'b0;
  logic [1:0] din2 = '0;
  logic       dout, dout_en;
  logic [1:0] dout2;
  logic       dout_en2;
  int checks = 0, fails = 0;
  logic model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sqmem_top dut (.clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  sqmem_top #(.SIDE_BITS(2), .WORD_BITS(1)) dut2 (.clk(clk), .rst(rst),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr[2:0]), .din(din2),
    .dout(dout2), .dout_en(dout_en2));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; drives inputs, returns at the next negedge
  task automatic step(input logic c, input logic w, input logic o,
                      input logic [3:0] a, input logic d, input logic [1:0] d2);
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d; din2 = d2;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic d);
    step(0, 0, 1, a, d, 2'd0);
    step(0, 1, 1, a, d, 2'd0);
    step(1, 1, 1, a, d, 2'd0);
    model[a] = d;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a);
    step(0, 1, 0, a, 0, 2'd0);
    check({tag, " en"}, int'(dout_en), 1);
    check({tag, " data"}, int'(dout), int'(model[a]));
    step(1, 1, 1, a, 0, 2'd0);
  endtask

  task automatic t_reset;
    check("R6 dout_en after reset", int'(dout_en), 0);
    check("R6 dout after reset", int'(dout), 0);
  endtask

  task automatic t_fill;
    for (int a = 0; a < 16; a++) wr(4'(a), logic'(((a >> 2) ^ a ^ (a >> 1)) & 1));
    for (int a = 0; a < 16; a++) rd_check("R1 readback", 4'(a));
  endtask

  task automatic t_neighbours;
    wr(4'd6, ~model[6]);
    rd_check("R8 target", 4'd6);
    for (int k = 0; k < 4; k++) begin
      rd_check("R8 same row", 4'(4 + k));
      rd_check("R8 same column", 4'(k*4 + 2));
    end
  endtask

  task automatic t_release_sample;
    step(0, 0, 1, 4'd9, ~model[9], 2'd0);
    step(0, 0, 1, 4'd9, model[9], 2'd0);
    step(0, 1, 1, 4'd9, ~model[9], 2'd0);
    step(1, 1, 1, 4'd9, 0, 2'd0);
    model[9] = ~model[9];
    rd_check("R2 release-edge data", 4'd9);
    step(0, 0, 1, 4'd3, model[3], 2'd0);
    step(0, 0, 1, 4'd12, model[12], 2'd0);
    step(0, 1, 1, 4'd12, ~model[12], 2'd0);
    step(1, 1, 1, 4'd0, 0, 2'd0);
    model[12] = ~model[12];
    rd_check("R2 release-edge address", 4'd12);
    rd_check("R2 fall address untouched", 4'd3);
  endtask

  task automatic t_deselect;
    step(1, 1, 0, 4'd5, 0, 2'd0);
    check("R3 no drive when deselected", int'(dout_en), 0);
    check("R3 dout zero when deselected", int'(dout), 0);
    step(0, 0, 1, 4'd5, ~model[5], 2'd0);
    step(1, 1, 1, 4'd5, ~model[5], 2'd0);
    step(1, 1, 1, 4'd5, ~model[5], 2'd0);
    rd_check("R3 release while deselected", 4'd5);
    step(1, 0, 1, 4'd10, ~model[10], 2'd0);
    step(0, 1, 1, 4'd10, ~model[10], 2'd0);
    step(1, 1, 1, 4'd10, 0, 2'd0);
    rd_check("R3 fall while deselected", 4'd10);
  endtask

  task automatic t_controls;
    step(0, 1, 1, 4'd6, 0, 2'd0);
    check("R4 oe high no drive", int'(dout_en), 0);
    check("R4 oe high dout zero", int'(dout), 0);
    step(0, 0, 0, 4'd6, model[6], 2'd0);
    check("R5 write wins over read", int'(dout_en), 0);
    step(0, 1, 1, 4'd6, model[6], 2'd0);
    step(1, 1, 1, 4'd6, 0, 2'd0);
    rd_check("R5 cell after overlapped write", 4'd6);
  endtask

  task automatic t_wide;
    logic [1:0] m2 [8];
    for (int a = 0; a < 8; a++) begin
      m2[a] = 2'((a * 3 + 1) & 3);
      step(0, 0, 1, 4'(a), 0, m2[a]);
      step(0, 1, 1, 4'(a), 0, m2[a]);
      step(1, 1, 1, 4'(a), 0, 2'd0);
    end
    for (int a = 0; a < 8; a++) begin
      step(0, 1, 0, 4'(a), 0, 2'd0);
      check("R7 wide en", int'(dout_en2), 1);
      check("R7 wide data", int'(dout2), int'(m2[a]));
    end
    step(1, 1, 1, 4'd0, 0, 2'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_neighbours();
    t_release_sample();
    t_deselect();
    t_controls();
    t_wide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule